// File: doc/BRIEF.md
# Performance Counter Bank with Overflow Freeze

This block holds four event counters, each 48 bits wide and each governed by its own control register. Every cycle, each counter looks at one bit of a 32-bit event vector, picked by its 5-bit select field. If that bit is high, the counter's own enable is set and the global count enable is set, the counter adds one. The select-to-event mapping is rotated per counter, so a given select code names a different event on each counter.

Software reaches all state through a simple register bus: a one-cycle write strobe with address and data, and a read port that decodes the address combinationally. Count registers can be read at any time without stopping collection. A count register may be preloaded so that it wraps after a chosen number of events. When a counter wraps, a sticky status bit records it. If the counter's interrupt-enable bit is set, a one-cycle request goes to the global controller, which clears the global count enable a fixed number of cycles later and freezes every counter. Until the freeze lands, the counters keep counting, the wrapped one included. Software resumes collection by writing the global enable again.

Top module: `perfCounterBank`

## Requirements
- R1: After reset, every control register, every count register, the global enable (address 8, bit 0) and the overflow status (address 9) read zero, and irqReq is low.
- R2: Control registers sit at addresses 0 to 3, one per counter. Bit 0 is the counter enable, bits 5:1 are the event select and bit 20 is the overflow interrupt enable. Every other bit reads zero, whatever was written.
- R3: Count registers sit at addresses 4 to 7. Writes load bits 47:0, and bits 63:48 read zero. Reading a counter while it runs returns its current value and does not stop it.
- R4: Counter i with select s samples event bit (s + 8*i) mod 32. It adds exactly one on each clock edge where its enable, the global enable and that event bit are all 1, and it holds otherwise.
- R5: An increment from all ones wraps the counter to zero and sets status bit i (address 9). Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A new overflow wins over a clear in the same cycle.
- R6: A wrap on a counter whose interrupt enable is set drives irqReq high for one cycle, in the cycle after the wrapping edge. A wrap with the interrupt enable clear raises no request.
- R7: The global enable reads 0 starting two cycles after irqReq is high. Counters keep counting during those two cycles, so a counter preloaded with all ones and fed a constant event freezes at 2. A freeze wins over a global-enable write in the same cycle.
- R8: A counter loaded with (2^48 - 1) - N reads all ones after N counted events, with no status bit set, and wraps on the next event.
- R9: A bus write to a count register in a cycle where that counter would also increment loads the written value and discards the increment.
- R10: Writing 1 to global enable bit 0 after a freeze restarts counting on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe, one cycle per write |
| busAddr | input | 4 | Register address for both read and write |
| busWrData | input | 64 | Register write data |
| busRdData | output | 64 | Read data for busAddr, combinational |
| events | input | 32 | Event vector, one bit per event source |
| irqReq | output | 1 | Overflow interrupt request pulse |

## Verification
The assertions assume that every bus write lasts exactly one cycle. They also assume that no software write to the global enable lands inside the short window between a request and its freeze, because a write there would hide the freeze from the sequence the checker expects. The bench drives the bus only through a single-cycle write task. It changes events and bus inputs only on falling edges. It rewrites the global enable only after the frozen state has been observed.

// File: rtl/pcb_pkg.sv
`timescale 1ns/1ps
package pcb_pkg;
  localparam int PCB_NUM_CTR  = 4;
  localparam int PCB_CNT_W    = 48;
  localparam int PCB_EVT_W    = 32;
  localparam int PCB_SEL_W    = 5;
  localparam int PCB_DATA_W   = 64;
  localparam int PCB_ADDR_W   = 4;

  // control register field positions (decoded by software)
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_SEL_LSB  = 1;
  localparam int CTL_IRQ_BIT  = 20;

  // per-counter strobes from control to datapath
  typedef struct packed {
    logic ctlWr;
    logic cntWr;
  } pcbStrobe_t;
endpackage

// File: rtl/pcbEventSel.sv
`timescale 1ns/1ps
module pcbEventSel #(
  parameter int EVT_W   = 32,
  parameter int SEL_W   = 5,
  parameter int CTR_IDX = 0,
  parameter int STRIDE  = 8
) (
  input  logic [EVT_W-1:0] events,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  localparam int IDX_W  = (EVT_W > 1) ? $clog2(EVT_W) : 1;
  localparam int OFFSET = (CTR_IDX * STRIDE) % EVT_W;

  // rotated mapping: each counter sees its own event set
  always_comb begin
    int unsigned sum;
    sum = (int'(sel) + OFFSET) % EVT_W;
    hit = events[IDX_W'(sum)];
  end
endmodule

// File: rtl/pcbDatapath.sv
`timescale 1ns/1ps
module pcbDatapath
  import pcb_pkg::*;
#(
  parameter int NUM_CTR = PCB_NUM_CTR,
  parameter int CNT_W   = PCB_CNT_W,
  parameter int EVT_W   = PCB_EVT_W,
  parameter int SEL_W   = PCB_SEL_W,
  parameter int DATA_W  = PCB_DATA_W
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  pcbStrobe_t [NUM_CTR-1:0]        strb,
  input  logic                            globalEn,
  input  logic [DATA_W-1:0]               wrData,
  input  logic [EVT_W-1:0]                events,
  output logic [NUM_CTR-1:0][DATA_W-1:0]  ctlRegs,
  output logic [NUM_CTR-1:0][CNT_W-1:0]   cntVal,
  output logic [NUM_CTR-1:0]              ovfHit,
  output logic [NUM_CTR-1:0]              irqEnVec
);
  localparam logic [DATA_W-1:0] CTL_MASK =
      (DATA_W'(1) << CTL_EN_BIT) |
      (((DATA_W'(1) << SEL_W) - DATA_W'(1)) << CTL_SEL_LSB) |
      (DATA_W'(1) << CTL_IRQ_BIT);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic             evHit;
    logic             incr;
    logic             ctrEn;
    logic [SEL_W-1:0] ctrSel;

    assign ctrEn       = ctlRegs[i][CTL_EN_BIT];
    assign ctrSel      = ctlRegs[i][CTL_SEL_LSB +: SEL_W];
    assign irqEnVec[i] = ctlRegs[i][CTL_IRQ_BIT];

    pcbEventSel #(
      .EVT_W  (EVT_W),
      .SEL_W  (SEL_W),
      .CTR_IDX(i),
      .STRIDE (8)
    ) u_sel (
      .events(events),
      .sel   (ctrSel),
      .hit   (evHit)
    );

    assign incr      = ctrEn & globalEn & evHit;
    // a wrap only counts when the bus write does not override it
    assign ovfHit[i] = incr & ~strb[i].cntWr & (cntVal[i] == CNT_MAX);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctlRegs[i] <= '0;
      end else if (strb[i].ctlWr) begin
        ctlRegs[i] <= wrData & CTL_MASK;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntVal[i] <= '0;
      end else if (strb[i].cntWr) begin
        cntVal[i] <= wrData[CNT_W-1:0];
      end else if (incr) begin
        cntVal[i] <= cntVal[i] + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pcbControl.sv
`timescale 1ns/1ps
module pcbControl
  import pcb_pkg::*;
#(
  parameter int NUM_CTR    = PCB_NUM_CTR,
  parameter int CNT_W      = PCB_CNT_W,
  parameter int DATA_W     = PCB_DATA_W,
  parameter int ADDR_W     = PCB_ADDR_W,
  parameter int FREEZE_DLY = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            busWrEn,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic [DATA_W-1:0]               busWrData,
  output logic [DATA_W-1:0]               busRdData,
  input  logic [NUM_CTR-1:0][DATA_W-1:0]  ctlRegs,
  input  logic [NUM_CTR-1:0][CNT_W-1:0]   cntVal,
  input  logic [NUM_CTR-1:0]              ovfHit,
  input  logic [NUM_CTR-1:0]              irqEnVec,
  output pcbStrobe_t [NUM_CTR-1:0]        strb,
  output logic                            globalEn,
  output logic [NUM_CTR-1:0]              ovfStatus,
  output logic                            irqReq
);
  localparam logic [ADDR_W-1:0] CNT_BASE = ADDR_W'(NUM_CTR);
  localparam logic [ADDR_W-1:0] GLB_ADDR = ADDR_W'(2 * NUM_CTR);
  localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(2 * NUM_CTR + 1);
  localparam int PIPE_W = FREEZE_DLY - 1;

  logic glbWr;
  logic stsWr;
  logic freezeNow;
  logic [PIPE_W-1:0] freezePipe;
  logic [NUM_CTR-1:0] clrMask;

  // address decode into strobes
  always_comb begin
    for (int i = 0; i < NUM_CTR; i++) begin
      strb[i].ctlWr = busWrEn && (busAddr == ADDR_W'(i));
      strb[i].cntWr = busWrEn && (busAddr == CNT_BASE + ADDR_W'(i));
    end
  end
  assign glbWr   = busWrEn && (busAddr == GLB_ADDR);
  assign stsWr   = busWrEn && (busAddr == STS_ADDR);
  assign clrMask = stsWr ? busWrData[NUM_CTR-1:0] : '0;

  // interrupt request: one cycle after a wrap with interrupt enabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqReq <= 1'b0;
    else       irqReq <= |(ovfHit & irqEnVec);
  end

  // fixed-latency path from request to global disable
  if (PIPE_W == 1) begin : g_pipe1
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) freezePipe <= '0;
      else       freezePipe <= irqReq;
    end
  end else begin : g_pipeN
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) freezePipe <= '0;
      else       freezePipe <= {freezePipe[PIPE_W-2:0], irqReq};
    end
  end
  assign freezeNow = freezePipe[PIPE_W-1];

  // global enable: freeze has priority over software
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          globalEn <= 1'b0;
    else if (freezeNow) globalEn <= 1'b0;
    else if (glbWr)     globalEn <= busWrData[0];
  end

  // sticky status, write-one-to-clear, set beats clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfStatus <= '0;
    else       ovfStatus <= (ovfStatus & ~clrMask) | ovfHit;
  end

  // read mux
  always_comb begin
    busRdData = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (busAddr == ADDR_W'(i))            busRdData = ctlRegs[i];
      if (busAddr == CNT_BASE + ADDR_W'(i)) busRdData = DATA_W'(cntVal[i]);
    end
    if (busAddr == GLB_ADDR) busRdData = DATA_W'(globalEn);
    if (busAddr == STS_ADDR) busRdData = DATA_W'(ovfStatus);
  end
endmodule

// File: rtl/perfCounterBank.sv
`timescale 1ns/1ps
module perfCounterBank
  import pcb_pkg::*;
#(
  parameter int NUM_CTR    = PCB_NUM_CTR,
  parameter int CNT_W      = PCB_CNT_W,
  parameter int EVT_W      = PCB_EVT_W,
  parameter int SEL_W      = PCB_SEL_W,
  parameter int DATA_W     = PCB_DATA_W,
  parameter int ADDR_W     = PCB_ADDR_W,
  parameter int FREEZE_DLY = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [EVT_W-1:0]  events,
  output logic              irqReq
);
  pcbStrobe_t [NUM_CTR-1:0]        strb;
  logic                            globalEn;
  logic [NUM_CTR-1:0][DATA_W-1:0]  ctlRegs;
  logic [NUM_CTR-1:0][CNT_W-1:0]   cntVal;
  logic [NUM_CTR-1:0]              ovfHit;
  logic [NUM_CTR-1:0]              irqEnVec;
  logic [NUM_CTR-1:0]              ovfStatus;
  logic [NUM_CTR-1:0]              cntWrVec;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_wrv
    assign cntWrVec[i] = strb[i].cntWr;
  end

  pcbControl #(
    .NUM_CTR   (NUM_CTR),
    .CNT_W     (CNT_W),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .FREEZE_DLY(FREEZE_DLY)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .ctlRegs  (ctlRegs),
    .cntVal   (cntVal),
    .ovfHit   (ovfHit),
    .irqEnVec (irqEnVec),
    .strb     (strb),
    .globalEn (globalEn),
    .ovfStatus(ovfStatus),
    .irqReq   (irqReq)
  );

  pcbDatapath #(
    .NUM_CTR(NUM_CTR),
    .CNT_W  (CNT_W),
    .EVT_W  (EVT_W),
    .SEL_W  (SEL_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .globalEn(globalEn),
    .wrData  (busWrData),
    .events  (events),
    .ctlRegs (ctlRegs),
    .cntVal  (cntVal),
    .ovfHit  (ovfHit),
    .irqEnVec(irqEnVec)
  );
endmodule

// File: rtl/pcbChecker.sv
`timescale 1ns/1ps
module pcbChecker
  import pcb_pkg::*;
#(
  parameter int NUM_CTR    = PCB_NUM_CTR,
  parameter int CNT_W      = PCB_CNT_W,
  parameter int DATA_W     = PCB_DATA_W,
  parameter int ADDR_W     = PCB_ADDR_W,
  parameter int SEL_W      = PCB_SEL_W,
  parameter int FREEZE_DLY = 2
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [ADDR_W-1:0]             busAddr,
  input logic [DATA_W-1:0]             busRdData,
  input logic                          irqReq,
  input logic                          globalEn,
  input logic [NUM_CTR-1:0]            ovfStatus,
  input logic [NUM_CTR-1:0][CNT_W-1:0] cntVal,
  input logic [NUM_CTR-1:0]            cntWrVec
);
  localparam logic [DATA_W-1:0] FIELD_MASK =
      (DATA_W'(1) << CTL_EN_BIT) |
      (((DATA_W'(1) << SEL_W) - DATA_W'(1)) << CTL_SEL_LSB) |
      (DATA_W'(1) << CTL_IRQ_BIT);

  // cycles since the latest request, counted in the checker
  logic       tracking;
  logic [7:0] reqAge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tracking <= 1'b0;
      reqAge   <= '0;
    end else if (irqReq) begin
      tracking <= 1'b1;
      reqAge   <= 8'd1;
    end else if (tracking) begin
      if (reqAge == 8'(FREEZE_DLY)) tracking <= 1'b0;
      else reqAge <= reqAge + 8'd1;
    end
  end

  // R7
  freeze_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tracking && reqAge == 8'(FREEZE_DLY)) |-> !globalEn);

  // R2
  ctl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr < ADDR_W'(NUM_CTR)) |-> ((busRdData & ~FIELD_MASK) == '0));

  // R3
  cnt_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr >= ADDR_W'(NUM_CTR) && busAddr < ADDR_W'(2 * NUM_CTR))
      |-> (busRdData[DATA_W-1:CNT_W] == '0));

  // R5
  status_on_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (ovfStatus != '0));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      !cntWrVec[i] |=> ((cntVal[i] == $past(cntVal[i])) ||
                        (cntVal[i] == $past(cntVal[i]) + CNT_W'(1))));
    // R7
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!globalEn && !cntWrVec[i]) |=> $stable(cntVal[i]));
  end
endmodule

bind perfCounterBank pcbChecker #(
  .NUM_CTR   (NUM_CTR),
  .CNT_W     (CNT_W),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .SEL_W     (SEL_W),
  .FREEZE_DLY(FREEZE_DLY)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busRdData(busRdData),
  .irqReq   (irqReq),
  .globalEn (globalEn),
  .ovfStatus(ovfStatus),
  .cntVal   (cntVal),
  .cntWrVec (cntWrVec)
);

// File: tb/tb_perfCounterBank.sv
`timescale 1ns/1ps
module tb_perfCounterBank;
  logic        clk = 1'b0;
  logic        rstN;
  logic        busWrEn;
  logic [3:0]  busAddr;
  logic [63:0] busWrData;
  logic [63:0] busRdData;
  logic [31:0] events;
  logic        irqReq;

  int checks = 0;
  int errors = 0;
  int irqSeen = 0;
  logic [63:0] rv;

  localparam logic [47:0] ALL1 = '1;

  // rows: {counter[1:0], select[4:0], event vector[31:0], expected count[7:0]}
  localparam int NROWS = 8;
  localparam logic [46:0] ROWS [NROWS] = '{
    {2'd0, 5'd0,  32'h0000_0001, 8'd4},
    {2'd1, 5'd0,  32'h0000_0001, 8'd0},
    {2'd1, 5'd0,  32'h0000_0100, 8'd4},
    {2'd2, 5'd3,  32'h0008_0000, 8'd4},
    {2'd3, 5'd10, 32'h0000_0004, 8'd4},
    {2'd3, 5'd10, 32'h0000_0400, 8'd0},
    {2'd0, 5'd31, 32'h8000_0000, 8'd4},
    {2'd2, 5'd31, 32'h0000_8000, 8'd4}
  };

  perfCounterBank dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .events(events),
    .irqReq(irqReq)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (irqReq) irqSeen++;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called just after a falling edge; returns after the next one
  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; busWrEn = 1'b0; busAddr = '0; busWrData = '0; events = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(4'd0, rv); check("R1 ctl0", rv, 64'd0);
    rd(4'd5, rv); check("R1 cnt1", rv, 64'd0);
    rd(4'd8, rv); check("R1 global", rv, 64'd0);
    rd(4'd9, rv); check("R1 status", rv, 64'd0);
    check("R1 irq", {63'd0, irqReq}, 64'd0);

    // R2 control field mask
    wr(4'd1, '1);
    rd(4'd1, rv); check("R2 ctl mask", rv, 64'h0000_0000_0010_003F);

    // R3 count write, upper bits zero
    wr(4'd6, 64'hFFFF_1234_5678_9ABC);
    rd(4'd6, rv); check("R3 cnt width", rv, 64'h0000_1234_5678_9ABC);

    // R4 event mapping table
    wr(4'd8, 64'd1);
    for (int r = 0; r < NROWS; r++) begin
      logic [1:0]  c;
      logic [4:0]  s;
      logic [31:0] v;
      logic [7:0]  e;
      {c, s, v, e} = ROWS[r];
      wr({2'b00, c}, {58'd0, s, 1'b1});
      wr({2'b01, c}, 64'd0);
      events = v;
      repeat (4) @(negedge clk);
      events = '0;
      rd({2'b01, c}, rv);
      check($sformatf("R4 row %0d", r), rv, {56'd0, e});
    end

    // R9 write beats increment; R3 read while counting (counter0 select 31 -> bit 31)
    events = 32'h8000_0000;
    wr(4'd4, 64'd100);
    rd(4'd4, rv); check("R9 write priority", rv, 64'd100);
    @(negedge clk);
    rd(4'd4, rv); check("R3 read while running", rv, 64'd101);
    events = '0;

    // R8 preload, no interrupt (counter1 select 0 -> bit 8)
    wr(4'd1, 64'd1);
    wr(4'd5, {16'd0, ALL1 - 48'd3});
    irqSeen = 0;
    events = 32'h0000_0100;
    repeat (3) @(negedge clk);
    events = '0;
    rd(4'd5, rv); check("R8 reaches all ones", rv, {16'd0, ALL1});
    rd(4'd9, rv); check("R8 no status yet", rv, 64'd0);
    events = 32'h0000_0100;
    @(negedge clk);
    events = '0;
    rd(4'd5, rv); check("R5 wrap to zero", rv, 64'd0);
    @(negedge clk);
    rd(4'd9, rv); check("R5 status set", rv, 64'h2);
    check("R6 no irq when disabled", irqSeen, 64'd0);
    wr(4'd9, 64'd0);
    rd(4'd9, rv); check("R5 write 0 keeps", rv, 64'h2);
    wr(4'd9, 64'h2);
    rd(4'd9, rv); check("R5 write 1 clears", rv, 64'd0);

    // R6/R7 freeze path (counter3 select 0 -> bit 24, interrupt on)
    wr(4'd3, 64'h0000_0000_0010_0001);
    wr(4'd7, {16'd0, ALL1});
    irqSeen = 0;
    events = 32'h0100_0000;
    @(negedge clk);
    check("R6 irq after wrap", {63'd0, irqReq}, 64'd1);
    rd(4'd7, rv); check("R7 wrapped", rv, 64'd0);
    rd(4'd8, rv); check("R7 still enabled", rv, 64'd1);
    @(negedge clk);
    check("R6 irq one cycle", {63'd0, irqReq}, 64'd0);
    rd(4'd7, rv); check("R7 counts after wrap", rv, 64'd1);
    @(negedge clk);
    rd(4'd8, rv); check("R7 global cleared", rv, 64'd0);
    rd(4'd7, rv); check("R7 frozen value", rv, 64'd2);
    repeat (3) @(negedge clk);
    rd(4'd7, rv); check("R7 stays frozen", rv, 64'd2);
    rd(4'd9, rv); check("R5 status counter3", rv, 64'h8);
    check("R6 single request", irqSeen, 64'd1);

    // R10 restart
    wr(4'd8, 64'd1);
    rd(4'd7, rv); check("R10 no count on write edge", rv, 64'd2);
    @(negedge clk);
    rd(4'd7, rv); check("R10 counting resumed", rv, 64'd3);
    events = '0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule